// File: doc/BRIEF.md
# Audio Master Clock Divider

This block turns a fast audio source clock into the three timing signals an audio serial port needs when it runs as timing master: a divided master clock, a serial bit clock and a one-cycle frame-start strobe. All three are produced as levels and pulses in the source clock domain by counters, so downstream logic can use them as clock enables or drive pins from registers.

Two 6-bit ratio fields set the timing. The divide field `div_cfg` gives a master clock of source/(div_cfg+1). The frame field `fs_cfg` gives a frame of 32·(fs_cfg+1) source cycles. Together the master clock runs at 32·(fs_cfg+1)/(div_cfg+1) times the frame rate. A routing bit chooses whether the master clock is brought out at all. The generator runs only in master mode, and it runs between a start pulse and a stop pulse. Ratio changes made while it runs are held back until the next frame starts, so a frame is never cut short or stretched.

Top module: `audio_clkgen`

## Requirements
- R1: After reset, `frame_o`, `bclk_o` and `mck_o` are all 0 and stay 0 until a start pulse is accepted.
- R2: A `ck_start` pulse is accepted only while `master_sel` is 1. A start pulse given while `master_sel` is 0 has no effect, even after `master_sel` later rises. While `master_sel` is 0, all three outputs are 0.
- R3: A `ck_stop` pulse stops the generator, and it wins over a simultaneous `ck_start`. All outputs are 0 from the cycle after the pulse. Dropping `master_sel` also stops it, and raising `master_sel` again does not restart it without a new start pulse.
- R4: `frame_o` is high for exactly one source cycle, first in the cycle right after the accepted start edge, and then once every 32·(F+1) cycles, where F is the active frame field.
- R5: With N = D+1 for the active divide field D, the master clock level has period N. It is high for ceil(N/2) cycles and low for floor(N/2) cycles, so an odd N gives the longer high phase. The pattern restarts high at every frame start, and D=0 gives a steady high level.
- R6: `mck_o` carries the master clock level only while `mck_out_sel` is 1. While it is 0, `mck_o` is held at 0.
- R7: `bclk_o` is 0 in each frame-start cycle and toggles every H cycles, where H = max(1, floor((F+1)/4)). This gives 64 bit-clock periods per frame when F+1 is a multiple of 4.
- R8: A change of `div_cfg` or `fs_cfg` while running takes effect only at the next frame start. The current frame keeps its length and its clock pattern.
- R9: The ratio examples hold. D=7 with F=63 gives 256 master clock periods per frame, and D=7 with F=15 gives 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast audio source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_sel | input | 1 | 1 = timing master (clocks generated), 0 = follower |
| mck_out_sel | input | 1 | 1 = bring out the master clock on `mck_o` |
| div_cfg | input | 6 | Master clock divide field D (ratio D+1) |
| fs_cfg | input | 6 | Frame field F (frame of 32·(F+1) cycles) |
| ck_start | input | 1 | One-cycle start command |
| ck_stop | input | 1 | One-cycle stop command |
| mck_o | output | 1 | Master clock level |
| bclk_o | output | 1 | Bit clock level |
| frame_o | output | 1 | Frame-start strobe |

## Verification
A wrong frame counter shows up on `frame_o` as a strobe early or late within one frame of 32 to 2048 cycles. Because the bit and master dividers restart at each strobe, the same fault also breaks the phase of `bclk_o` and `mck_o` in that frame. A divider that is off by one drifts within its first period after a frame start and is seen within N or H cycles. A ratio field taken up too early changes the strobe spacing of the frame that is in progress. A run flag that does not clear correctly leaves outputs toggling in the first cycle after a stop or a change out of master mode.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

  // source cycles in one frame for frame field fs
  function automatic int unsigned frame_len(input int unsigned fs);
    return 32 * (fs + 1);
  endfunction

  // high-phase length of the master clock for divide field div: ceil((div+1)/2)
  function automatic int unsigned mck_high(input int unsigned div);
    return (div + 2) / 2;
  endfunction

  // half period of the bit clock in source cycles, never below one
  function automatic int unsigned bclk_half(input int unsigned fs);
    int unsigned h;
    h = (fs + 1) >> 2;
    return (h == 0) ? 1 : h;
  endfunction

endpackage

// File: rtl/agc_frame_ctr.sv
module agc_frame_ctr
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int FS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [DIV_W-1:0] div_in,
  input  logic [FS_W-1:0]  fs_in,
  output logic [DIV_W-1:0] act_div,
  output logic [FS_W-1:0]  act_fs,
  output logic             wrap,
  output logic             at_start
);
  localparam int CNT_W = FS_W + 5;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  assign last     = CNT_W'(frame_len(32'(act_fs)) - 1);
  assign wrap     = active && (cnt == last);
  assign at_start = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      act_div <= '0;
      act_fs  <= '0;
    end else if (!active || wrap) begin
      cnt     <= '0;
      act_div <= div_in;
      act_fs  <= fs_in;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/agc_mck_div.sv
module agc_mck_div
  import audio_clkgen_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             mck_lvl
);
  localparam int CMP_W = DIV_W + 1;

  logic [DIV_W-1:0] mcnt;

  assign mck_lvl = CMP_W'(mcnt) < CMP_W'(mck_high(32'(div)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mcnt <= '0;
    else if (!active || restart) mcnt <= '0;
    else if (mcnt == div)        mcnt <= '0;
    else                         mcnt <= mcnt + 1'b1;
  end
endmodule

// File: rtl/agc_bclk_div.sv
module agc_bclk_div
  import audio_clkgen_pkg::*;
#(
  parameter int FS_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            restart,
  input  logic [FS_W-1:0] fs,
  output logic            bclk_lvl
);
  logic [FS_W-1:0] bcnt;
  logic [FS_W-1:0] half_m1;

  assign half_m1 = FS_W'(bclk_half(32'(fs)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt     <= '0;
      bclk_lvl <= 1'b0;
    end else if (!active || restart) begin
      bcnt     <= '0;
      bclk_lvl <= 1'b0;
    end else if (bcnt == half_m1) begin
      bcnt     <= '0;
      bclk_lvl <= ~bclk_lvl;
    end else begin
      bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int DIV_W = 6,
  parameter int FS_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_sel,
  input  logic             mck_out_sel,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [FS_W-1:0]  fs_cfg,
  input  logic             ck_start,
  input  logic             ck_stop,
  output logic             mck_o,
  output logic             bclk_o,
  output logic             frame_o
);
  logic             run_q;
  logic             active;
  logic             frame_wrap;
  logic             at_start;
  logic [DIV_W-1:0] cur_div;
  logic [FS_W-1:0]  cur_fs;
  logic             mck_lvl;
  logic             bclk_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     run_q <= 1'b0;
    else if (ck_stop || !master_sel) run_q <= 1'b0;
    else if (ck_start)              run_q <= 1'b1;
  end

  assign active = run_q && master_sel;

  agc_frame_ctr #(.DIV_W(DIV_W), .FS_W(FS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .active(active),
    .div_in(div_cfg), .fs_in(fs_cfg),
    .act_div(cur_div), .act_fs(cur_fs),
    .wrap(frame_wrap), .at_start(at_start)
  );

  agc_mck_div #(.DIV_W(DIV_W)) u_mck (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(frame_wrap),
    .div(cur_div), .mck_lvl(mck_lvl)
  );

  agc_bclk_div #(.FS_W(FS_W)) u_bclk (
    .clk(clk), .rst_n(rst_n), .active(active), .restart(frame_wrap),
    .fs(cur_fs), .bclk_lvl(bclk_lvl)
  );

  assign frame_o = active && at_start;
  assign mck_o   = active && mck_out_sel && mck_lvl;
  assign bclk_o  = active && bclk_lvl;
endmodule

// File: rtl/audio_clkgen_chk.sv
module audio_clkgen_chk #(
  parameter int DIV_W = 6,
  parameter int FS_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             master_sel,
  input logic             mck_out_sel,
  input logic             ck_stop,
  input logic             active,
  input logic [DIV_W-1:0] cur_div,
  input logic [FS_W-1:0]  cur_fs,
  input logic             mck_o,
  input logic             bclk_o,
  input logic             frame_o
);
  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);

  // R7
  bclk_low_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> !bclk_o);

  // R5
  mck_high_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (mck_o == mck_out_sel));

  // R6
  mck_suppressed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mck_out_sel |-> !mck_o);

  // R2
  slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_sel |-> !(frame_o || bclk_o || mck_o));

  // R3
  stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ck_stop |=> !(frame_o || bclk_o || mck_o));

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !frame_o) |-> ($stable(cur_fs) && $stable(cur_div)));
endmodule

bind audio_clkgen audio_clkgen_chk #(.DIV_W(DIV_W), .FS_W(FS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .mck_out_sel(mck_out_sel),
  .ck_stop(ck_stop), .active(active), .cur_div(cur_div), .cur_fs(cur_fs),
  .mck_o(mck_o), .bclk_o(bclk_o), .frame_o(frame_o)
);

// File: tb/audio_clkgen_tb.sv
`timescale 1ns/1ps
module audio_clkgen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_sel = 1'b0, mck_out_sel = 1'b0, ck_start = 1'b0, ck_stop = 1'b0;
  logic [5:0] div_cfg = '0, fs_cfg = '0;
  logic mck_o, bclk_o, frame_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  audio_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .master_sel(master_sel), .mck_out_sel(mck_out_sel),
    .div_cfg(div_cfg), .fs_cfg(fs_cfg), .ck_start(ck_start), .ck_stop(ck_stop),
    .mck_o(mck_o), .bclk_o(bclk_o), .frame_o(frame_o)
  );

  // vector table: divide field, frame field, route bit
  localparam int NV = 6;
  localparam int V_DIV [NV] = '{7, 7, 0, 2, 4, 1};
  localparam int V_FS  [NV] = '{63, 15, 3, 7, 11, 31};
  localparam int V_SEL [NV] = '{1, 1, 1, 1, 0, 1};

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // expected levels at frame position p
  function automatic int exp_mck(input int p, input int div, input int sel);
    int n;
    n = div + 1;
    return (sel != 0 && (p % n) < (n + 1) / 2) ? 1 : 0;
  endfunction

  function automatic int exp_bclk(input int p, input int fs);
    int h;
    h = (fs + 1) / 4;
    if (h < 1) h = 1;
    return (p / h) % 2;
  endfunction

  task automatic start_gen();
    ck_start = 1'b1;
    step();
    ck_start = 1'b0;
  endtask

  task automatic stop_gen();
    ck_stop = 1'b1;
    step();
    ck_stop = 1'b0;
  endtask

  int quiet;

  task automatic count_quiet(input int cycles);
    quiet = 0;
    for (int t = 0; t < cycles; t++) begin
      if (mck_o || bclk_o || frame_o) quiet++;
      step();
    end
  endtask

  initial begin
    int e_fr, e_mck, e_bclk, rises, prev, flen;
    #200000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int e_fr, e_mck, e_bclk, rises, prev, flen, p;
    step();
    // R1 reset state
    chk("R1 reset outputs", int'({mck_o, bclk_o, frame_o}), 0);
    rst_n = 1'b1;
    step();
    count_quiet(40);
    chk("R1 idle before start", quiet, 0);

    // vector loop: R4 R5 R6 R7 R9
    master_sel = 1'b1;
    for (int i = 0; i < NV; i++) begin
      stop_gen();
      div_cfg = 6'(V_DIV[i]);
      fs_cfg = 6'(V_FS[i]);
      mck_out_sel = V_SEL[i][0];
      start_gen();
      flen = 32 * (V_FS[i] + 1);
      e_fr = 0; e_mck = 0; e_bclk = 0; rises = 0; prev = 0;
      for (int t = 0; t < 2 * flen; t++) begin
        p = t % flen;
        if (int'(frame_o) != ((p == 0) ? 1 : 0)) e_fr++;
        if (int'(mck_o) != exp_mck(p, V_DIV[i], V_SEL[i])) e_mck++;
        if (int'(bclk_o) != exp_bclk(p, V_FS[i])) e_bclk++;
        if (t < flen && mck_o && (p == 0 || prev == 0)) rises++;
        prev = int'(mck_o);
        step();
      end
      chk($sformatf("R4 frame strobe mismatches vec%0d", i), e_fr, 0);
      chk($sformatf("R5/R6 mck mismatches vec%0d", i), e_mck, 0);
      chk($sformatf("R7 bclk mismatches vec%0d", i), e_bclk, 0);
      if (i == 0) chk("R9 256 mck periods per frame", rises, 256);
      if (i == 1) chk("R9 64 mck periods per frame", rises, 64);
    end

    // R8 mid-frame ratio change: old frame 512 cycles D=7, then 128 cycles D=2
    stop_gen();
    mck_out_sel = 1'b1;
    div_cfg = 6'd7;
    fs_cfg = 6'd15;
    start_gen();
    e_fr = 0; e_mck = 0; e_bclk = 0;
    for (int t = 0; t < 512 + 256; t++) begin
      if (t == 100) begin
        div_cfg = 6'd2;
        fs_cfg = 6'd3;
      end
      if (t < 512) begin
        p = t;
        if (int'(frame_o) != ((p == 0) ? 1 : 0)) e_fr++;
        if (int'(mck_o) != exp_mck(p, 7, 1)) e_mck++;
        if (int'(bclk_o) != exp_bclk(p, 15)) e_bclk++;
      end else begin
        p = (t - 512) % 128;
        if (int'(frame_o) != ((p == 0) ? 1 : 0)) e_fr++;
        if (int'(mck_o) != exp_mck(p, 2, 1)) e_mck++;
        if (int'(bclk_o) != exp_bclk(p, 3)) e_bclk++;
      end
      step();
    end
    chk("R8 strobe spacing across change", e_fr, 0);
    chk("R8 mck pattern across change", e_mck, 0);
    chk("R8 bclk pattern across change", e_bclk, 0);

    // R3 stop wins over simultaneous start
    ck_stop = 1'b1;
    ck_start = 1'b1;
    step();
    ck_stop = 1'b0;
    ck_start = 1'b0;
    count_quiet(200);
    chk("R3 stop beats start, outputs quiet", quiet, 0);

    // R3 leaving master mode stops; re-entering needs a new start
    start_gen();
    chk("R4 strobe right after start", int'(frame_o), 1);
    step();
    step();
    master_sel = 1'b0;
    #0.5;
    chk("R2 follower mode outputs low", int'({mck_o, bclk_o, frame_o}), 0);
    step();
    master_sel = 1'b1;
    count_quiet(200);
    chk("R3 no restart after master returns", quiet, 0);

    // R2 start ignored in follower mode
    master_sel = 1'b0;
    start_gen();
    master_sel = 1'b1;
    count_quiet(200);
    chk("R2 start in follower mode ignored", quiet, 0);

    // R5 DIV=0 gives steady high master clock
    stop_gen();
    div_cfg = 6'd0;
    fs_cfg = 6'd1;
    mck_out_sel = 1'b1;
    start_gen();
    e_mck = 0;
    for (int t = 0; t < 150; t++) begin
      if (!mck_o) e_mck++;
      step();
    end
    chk("R5 divide-by-one steady high", e_mck, 0);
    stop_gen();
    chk("R3 outputs low after stop", int'({mck_o, bclk_o, frame_o}), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule